// File: doc/BRIEF.md
# Full-Step Bipolar Gate Sequencer

This block drives two bipolar full bridges, one per motor winding, for a stepping motor that runs in full steps. A one-hot ring of four flip-flops holds the electrical position. Each clock cycle in which the step input is high moves the ring one position. The direction input picks which way it moves. In every position both windings are energised. From the ring position, each winding gets a polarity request (positive or negative), and the current regulator gates that request through a per-winding enable.

Each winding has a leg controller, a small state machine with four named states. `LEG_OFF` has both commands low. `LEG_POS` has the positive command high. `LEG_NEG` has the negative command high. `LEG_DEAD` is a timed gap with both commands low. The transitions are as follows:
- OFF→POS or OFF→NEG happens at once when a drive is requested.
- POS→DEAD or NEG→DEAD happens as soon as the request stops matching the driven polarity. This covers a polarity change and an enable that goes low.
- DEAD→(OFF, POS or NEG) happens after exactly `DEAD_CYCLES` cycles. The leg then follows whatever is requested at that moment.

A step that arrives during a gap is still taken into the ring. The changed polarity only shows once the gap has run out. The default gap is 24 cycles, which is 1 µs at 24 MHz.

Top module: `stepgate_top`

## Requirements
- R1: After reset the ring is in position 0, and all four gate outputs are low until a winding's enable is sampled high. The first enable then drives that winding's position-0 polarity on the next clock edge.
- R2: The ring holds exactly one active position at all times. With both enables high and settled, each winding has exactly one of its two commands high.
- R3: With dir_i=1, successive steps visit positions 0,1,2,3,0. Winding polarities per position are: 0:(A+,B+), 1:(A−,B+), 2:(A−,B−), 3:(A+,B−).
- R4: With dir_i=0, steps visit the same positions in the order 0,3,2,1,0.
- R5: Every clock cycle with step_i high moves the ring exactly one position. With step_i low the position does not change.
- R6: The positive and negative commands of one winding are never high in the same cycle.
- R7: When a winding's polarity reverses, both its commands are low for exactly DEAD_CYCLES cycles. The new command rises DEAD_CYCLES+1 edges after the edge that samples the step. A step moves only one winding, and the other winding's command stays high throughout.
- R8: Steps sampled during a gap still advance the ring. After the gap, the winding drives the polarity of the latest position and never shows an intermediate polarity.
- R9: When a winding's enable is sampled low, both its commands are low from the next edge onward. Re-enabling after the gap drives on the next edge. Re-enabling during the gap drives once the gap has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Step request, one position per high cycle |
| dir_i | input | 1 | 1 = forward order, 0 = reverse order |
| pwm_en_a_i | input | 1 | Chopper enable for winding A |
| pwm_en_b_i | input | 1 | Chopper enable for winding B |
| a_pos_o | output | 1 | Winding A positive-polarity gate request |
| a_neg_o | output | 1 | Winding A negative-polarity gate request |
| b_pos_o | output | 1 | Winding B positive-polarity gate request |
| b_neg_o | output | 1 | Winding B negative-polarity gate request |

## Verification
The bench sweeps eight steps in each direction and then a mixed direction pattern, predicting every position arithmetically. A ring that rotated the wrong way or lost its single active bit would show wrong polarities there. It measures the gap cycle by cycle: a gap one cycle short, or a leg that switched straight across, would show up as a wrong gap count or a shoot-through cycle. It also sends bursts of steps inside a gap. A leg that dropped those steps, or flashed an intermediate polarity, would end in the wrong position or record negative drive cycles. Enable drops and re-enables are timed both inside and after the gap, to catch a leg that ignores the enable or skips the gap.

// File: rtl/stepgate_pkg.sv
package stepgate_pkg;
    typedef enum logic [1:0] {
        LEG_OFF  = 2'd0,
        LEG_DEAD = 2'd1,
        LEG_POS  = 2'd2,
        LEG_NEG  = 2'd3
    } leg_state_e;

    localparam int unsigned RING_W    = 4;
    localparam int unsigned WINDING_N = 2;
endpackage

// File: rtl/stepgate_ring.sv
module stepgate_ring
    import stepgate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic dir_i,
    output logic a_want_pos_o,
    output logic b_want_pos_o
);
    logic [RING_W-1:0] ring_q;
    logic [RING_W-1:0] ring_d;

    // next position: rotate up for forward, down for reverse
    always_comb begin
        ring_d = ring_q;
        if (step_i) begin
            if (dir_i) ring_d = {ring_q[RING_W-2:0], ring_q[RING_W-1]};
            else       ring_d = {ring_q[0], ring_q[RING_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ring_q <= RING_W'(1);
        else        ring_q <= ring_d;
    end

    // positions 0 and 3 drive A positive, positions 0 and 1 drive B positive
    always_comb begin
        a_want_pos_o = ring_q[0] | ring_q[3];
        b_want_pos_o = ring_q[0] | ring_q[1];
    end

    p_ring_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ring_q) == 1);

    p_ring_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && dir_i) |=> ring_q == {$past(ring_q[2:0]), $past(ring_q[3])});

    p_ring_rev_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !dir_i) |=> ring_q == {$past(ring_q[0]), $past(ring_q[3:1])});

    p_ring_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(ring_q));
endmodule

// File: rtl/stepgate_leg.sv
module stepgate_leg
    import stepgate_pkg::*;
#(
    parameter int unsigned DEAD_CYCLES = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic want_pos_i,
    output logic pos_o,
    output logic neg_o
);
    localparam int unsigned CNT_W = $clog2(DEAD_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEAD_CYCLES - 1);

    leg_state_e st_q, st_d, target;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        if (!en_i)          target = LEG_OFF;
        else if (want_pos_i) target = LEG_POS;
        else                target = LEG_NEG;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LEG_OFF:  st_d = target;
            LEG_POS:  if (target != LEG_POS) st_d = LEG_DEAD;
            LEG_NEG:  if (target != LEG_NEG) st_d = LEG_DEAD;
            LEG_DEAD: if (cnt_q == LAST) st_d = target;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= LEG_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= (st_q == LEG_DEAD) ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        pos_o = (st_q == LEG_POS);
        neg_o = (st_q == LEG_NEG);
    end

    p_on_after_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pos_o) || $rose(neg_o)) |->
            ($past(st_q) == LEG_OFF || $past(cnt_q) == LAST));

    p_hold_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_o && en_i && want_pos_i) |=> pos_o);

    p_disable_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!pos_o && !neg_o));
endmodule

// File: rtl/stepgate_top.sv
module stepgate_top
    import stepgate_pkg::*;
#(
    parameter int unsigned DEAD_CYCLES = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic dir_i,
    input  logic pwm_en_a_i,
    input  logic pwm_en_b_i,
    output logic a_pos_o,
    output logic a_neg_o,
    output logic b_pos_o,
    output logic b_neg_o
);
    logic [WINDING_N-1:0] want_pos;
    logic [WINDING_N-1:0] en;
    logic [WINDING_N-1:0] pos;
    logic [WINDING_N-1:0] neg;

    stepgate_ring u_ring (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_i       (step_i),
        .dir_i        (dir_i),
        .a_want_pos_o (want_pos[0]),
        .b_want_pos_o (want_pos[1])
    );

    assign en = {pwm_en_b_i, pwm_en_a_i};

    for (genvar w = 0; w < WINDING_N; w++) begin : g_leg
        stepgate_leg #(.DEAD_CYCLES(DEAD_CYCLES)) u_leg (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_i       (en[w]),
            .want_pos_i (want_pos[w]),
            .pos_o      (pos[w]),
            .neg_o      (neg[w])
        );
    end

    assign a_pos_o = pos[0];
    assign a_neg_o = neg[0];
    assign b_pos_o = pos[1];
    assign b_neg_o = neg[1];

    p_no_shoot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_pos_o && a_neg_o) && !(b_pos_o && b_neg_o));

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !(a_pos_o || a_neg_o || b_pos_o || b_neg_o));
endmodule

// File: tb/stepgate_top_test.sv
module stepgate_top_test;
    localparam int DEAD = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_i = 1'b0, dir_i = 1'b1, en_a = 1'b0, en_b = 1'b0;
    logic a_pos, a_neg, b_pos, b_neg;

    int tests = 0, fails = 0, overlap = 0, pos_model = 0;

    always #5 clk = ~clk;

    stepgate_top #(.DEAD_CYCLES(DEAD)) uut (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .dir_i(dir_i),
        .pwm_en_a_i(en_a), .pwm_en_b_i(en_b),
        .a_pos_o(a_pos), .a_neg_o(a_neg), .b_pos_o(b_pos), .b_neg_o(b_neg)
    );

    always @(negedge clk)
        if (rst_n && ((a_pos && a_neg) || (b_pos && b_neg))) overlap++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected {a_pos,a_neg,b_pos,b_neg} for a position, both enabled
    function automatic int exp_vec(input int p);
        int ap = (p == 0 || p == 3) ? 1 : 0;
        int bp = (p == 0 || p == 1) ? 1 : 0;
        return (ap << 3) | ((1 - ap) << 2) | (bp << 1) | (1 - bp);
    endfunction

    function automatic int out_vec();
        return {28'd0, a_pos, a_neg, b_pos, b_neg};
    endfunction

    task automatic step_once(input bit d);
        step_i = 1'b1; dir_i = d;
        tick(1);
        step_i = 1'b0;
        pos_model = d ? (pos_model + 1) % 4 : (pos_model + 3) % 4;
    endtask

    task automatic check_pos(input string req);
        chk(out_vec() == exp_vec(pos_model), req, out_vec(), exp_vec(pos_model));
    endtask

    initial begin
        #(200000 * 10);
        fails++; tests++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int gap, lat, negs;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R1: quiet until enabled
        chk(out_vec() == 0, "R1 idle after reset", out_vec(), 0);
        en_a = 1'b1; en_b = 1'b1;
        tick(1);
        chk(out_vec() == exp_vec(0), "R1 first enable", out_vec(), exp_vec(0));

        // R3 / R2: forward sweep
        for (int i = 0; i < 8; i++) begin
            step_once(1'b1);
            tick(DEAD + 3);
            check_pos("R3 forward sweep");
        end
        // R4 / R2: reverse sweep
        for (int i = 0; i < 8; i++) begin
            step_once(1'b0);
            tick(DEAD + 3);
            check_pos("R4 reverse sweep");
        end
        // R2: mixed direction pattern
        for (int i = 0; i < 16; i++) begin
            step_once(((16'hB4D3 >> i) & 1) != 0);
            tick(DEAD + 3);
            check_pos("R2 mixed pattern");
        end

        // R5: no step, no change
        tick(60);
        check_pos("R5 hold without step");
        // R5: two-cycle step advances two positions
        step_i = 1'b1; dir_i = 1'b1;
        tick(2);
        step_i = 1'b0;
        pos_model = (pos_model + 2) % 4;
        tick(DEAD + 3);
        check_pos("R5 two-cycle step");

        // bring to position 0
        while (pos_model != 0) begin
            step_once(1'b1);
            tick(DEAD + 3);
        end
        check_pos("R3 return to position 0");

        // R7: gap length and latency, B unaffected
        step_once(1'b1);
        gap = 0; lat = 0; negs = 0;
        while (!a_neg && lat < 200) begin
            tick(1);
            lat++;
            if (!a_pos && !a_neg) gap++;
            if (!b_pos) negs++;
        end
        chk(gap == DEAD, "R7 gap length", gap, DEAD);
        chk(lat == DEAD + 1, "R7 turn-on latency", lat, DEAD + 1);
        chk(negs == 0, "R7 other winding undisturbed", negs, 0);
        tick(5);
        check_pos("R7 settled position 1");

        // R8: steps inside A's gap (1->2->3 flips A back to positive)
        step_once(1'b1);   // to 2: B flips
        tick(2);
        step_once(1'b1);   // to 3: A flips to positive
        tick(2);
        step_once(1'b0);   // back to 2
        tick(2);
        step_once(1'b1);   // to 3 again
        negs = 0; gap = 0;
        for (int i = 0; i < DEAD + 6; i++) begin
            tick(1);
            if (a_neg && i > 0) negs++;
            if (!a_pos && !a_neg) gap++;
        end
        chk(negs == 0, "R8 no intermediate polarity", negs, 0);
        tick(DEAD);
        check_pos("R8 steps kept during gap");
        // back to back steps on the same winding with a rising check on gap
        step_once(1'b1);   // to 0: A stays positive, B flips
        tick(1);
        step_once(1'b1);   // to 1: A flips inside B's gap
        gap = 0;
        while (!a_neg && gap < 200) begin
            tick(1);
            if (!a_pos) gap++;
        end
        chk(gap >= DEAD, "R8 gap not shortened", gap, DEAD);
        tick(DEAD + 3);
        check_pos("R8 final position");

        // R9: enable drop
        en_a = 1'b0;
        tick(1);
        chk({a_pos, a_neg} == 2'b00, "R9 off next edge", {a_pos, a_neg}, 0);
        tick(DEAD + 3);
        chk({a_pos, a_neg} == 2'b00, "R9 stays off", {a_pos, a_neg}, 0);
        chk({b_pos, b_neg} == (exp_vec(pos_model) & 3), "R9 B unaffected",
            {b_pos, b_neg}, exp_vec(pos_model) & 3);
        // R8/R5: steps while disabled are kept
        step_once(1'b1);
        tick(DEAD + 3);
        step_once(1'b1);
        tick(DEAD + 3);
        en_a = 1'b1;
        tick(1);
        check_pos("R9 re-enable after gap on next edge");
        // R9: re-enable inside gap
        en_a = 1'b0;
        tick(1);
        en_a = 1'b1;
        lat = 1;
        while (!(a_pos || a_neg) && lat < 200) begin
            tick(1);
            lat++;
        end
        chk(lat == DEAD + 1, "R9 re-enable inside gap waits", lat, DEAD + 1);
        check_pos("R9 polarity after re-enable");

        // R6: no shoot-through over the whole run
        chk(overlap == 0, "R6 no overlap cycles", overlap, 0);

        // R1: reset mid-run
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        en_a = 1'b0; en_b = 1'b0;
        tick(1);
        chk(out_vec() == 0, "R1 quiet after reset", out_vec(), 0);
        en_a = 1'b1; en_b = 1'b1;
        pos_model = 0;
        tick(1);
        check_pos("R1 position 0 after reset");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule